// File: doc/BRIEF.md
# Serial Channel-Word Loader for a Synthesiser Divider

This block is the programming front end of a frequency synthesiser. It receives channel words on a three-wire serial link. The link carries an active-low frame enable, a serial clock and a data line. The block captures one 8-bit word per frame and splits the word into two fields: a 6-bit swallow count (A) and a 2-bit code that selects the main divider modulus M from four values starting at 49. When the frame closes, the block fires a load strobe. The downstream divider counters use this strobe to clear themselves and take the new counts.

All three serial inputs are brought into the reference clock domain through a two-flip-flop synchroniser before any edge detection. When a frame opens, a blanking output is raised for a fixed number of reference cycles. This output gates the charge pump so that reprogramming glitches do not disturb the oscillator. A frame that closes with any bit count other than 8 is thrown away, and the counts already held stay in force.

A control FSM has four states:
- `ST_IDLE`: enable is deasserted.
- `ST_FRAME`: enable is asserted and bits are being shifted.
- `ST_COMMIT`: a single cycle in which the load strobe fires and the new counts are presented.
- `ST_DROP`: a single cycle in which a malformed frame is discarded.

The FSM has these transitions:
- IDLE→FRAME when the synchronised enable falls.
- FRAME→COMMIT when enable rises after exactly 8 bits.
- FRAME→DROP when enable rises after any other bit count.
- COMMIT→IDLE and DROP→IDLE after one cycle, or COMMIT→FRAME and DROP→FRAME if enable has already fallen again.

Top module: `synp_loader`

## Requirements
- R1: After reset, `a_count` is 0, `m_count` is 49, and `div_load` and `cp_blank` are low.
- R2: While the frame enable is low, each rising edge of the serial clock shifts in one data bit. The first bit of a frame is d7 and the last is d0.
- R3: `a_count` takes bits d5..d0, with d0 (the last bit sent) as its least significant bit. For example, A=5 is sent as d0..d5 = 1,0,1,0,0,0.
- R4: `m_count` equals 49 plus a 2-bit offset formed from d7 (MSB) and d6 (LSB). Listed as (d6,d7): (0,0) gives 49, (1,0) gives 50, (0,1) gives 51 and (1,1) gives 52.
- R5: When enable rises after exactly 8 bits, `div_load` goes high for exactly one cycle. The new counts are valid in that same cycle, which falls on the third reference clock edge after the enable change.
- R6: When enable rises after fewer or more than 8 bits, there is no strobe and `a_count` and `m_count` keep their previous values. The counts never change except in a strobe cycle.
- R7: `cp_blank` goes high on the third reference edge after enable falls. It stays high for exactly BLANK_CYCLES (default 16) cycles.
- R8: Serial clock edges while enable is high produce no strobe and change no count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en_n | input | 1 | Serial frame enable, active low |
| ser_clk | input | 1 | Serial bit clock; data is captured on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| a_count | output | 6 | Held swallow count A |
| m_count | output | 6 | Held main divider modulus M (49 to 52) |
| div_load | output | 1 | One-cycle clear-and-preload strobe for the divider counters |
| cp_blank | output | 1 | Charge pump blanking window |

## Verification
The bench sends words that set each M code and the extremes of A. A design that reversed the bit order, or swapped d6 and d7, would present wrong counts on the strobe. It then sends frames of 0, 7 and 9 bits. A design that trusted any frame, or did not saturate its bit counter, would fire a strobe or corrupt the held counts. The bench also checks the exact cycle of the strobe and of the blanking rise, and the length of every blanking run, so an extra or missing synchroniser stage or an off-by-one blanking counter is caught. Finally, it toggles the serial clock while enable is high, to catch a design that shifts or strobes outside a frame.

// File: rtl/synp_pkg.sv
package synp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FRAME  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_DROP   = 2'd3
    } synp_state_t;

endpackage

// File: rtl/synp_sync.sv
module synp_sync #(
    parameter int           W      = 3,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {STAGES{RST_VAL[b]}};
                end else if (STAGES == 1) begin
                    chain[0] <= d_async[b];
                end else begin
                    chain <= {chain[STAGES-2:0], d_async[b]};
                end
            end
            assign q_sync[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/synp_shift.sv
module synp_shift #(
    parameter int FRAME_BITS = 8,
    localparam int CNT_W = $clog2(FRAME_BITS + 2)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  shift_en,
    input  logic                  bit_in,
    output logic [FRAME_BITS-1:0] word,
    output logic [CNT_W-1:0]      nbits
);

    localparam logic [CNT_W-1:0] SAT = CNT_W'(FRAME_BITS + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word  <= '0;
            nbits <= '0;
        end else if (clear) begin
            word  <= '0;
            nbits <= '0;
        end else if (shift_en) begin
            word <= {word[FRAME_BITS-2:0], bit_in};
            if (nbits != SAT) begin
                nbits <= nbits + 1'b1;
            end
        end
    end

    // R2: the bit counter never runs past one beyond a full frame
    a_r2_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        nbits <= SAT);

    // R2: a shift moves the counter by one unless saturated
    a_r2_shift_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clear && nbits != SAT) |=> nbits == $past(nbits) + 1'b1);

endmodule

// File: rtl/synp_blank.sv
module synp_blank #(
    parameter int BLANK_CYCLES = 16,
    localparam int CW = $clog2(BLANK_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic blank_o
);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= CW'(BLANK_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign blank_o = (remain != '0);

    // R7: a start request opens the blanking window on the next cycle
    a_r7_blank_opens: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> blank_o);

    // R7: the window only closes when its count has run out
    a_r7_blank_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_o && !start && remain != CW'(1)) |=> blank_o);

endmodule

// File: rtl/synp_loader.sv
module synp_loader
    import synp_pkg::*;
#(
    parameter int A_W          = 6,
    parameter int M_W          = 2,
    parameter int M_BASE       = 49,
    parameter int BLANK_CYCLES = 16,
    parameter int SYNC_STAGES  = 2,
    localparam int FRAME_BITS  = A_W + M_W,
    localparam int M_CW        = $clog2(M_BASE + (1 << M_W)),
    localparam int CNT_W       = $clog2(FRAME_BITS + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_en_n,
    input  logic            ser_clk,
    input  logic            ser_dat,
    output logic [A_W-1:0]  a_count,
    output logic [M_CW-1:0] m_count,
    output logic            div_load,
    output logic            cp_blank
);

    // ---- synchronisation: bit 2 enable, bit 1 clock, bit 0 data
    logic [2:0] raw_in, syn_in;
    logic       en_s, sclk_s, dat_s;
    logic       en_d, sclk_d;

    assign raw_in = {ser_en_n, ser_clk, ser_dat};

    synp_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(raw_in),
        .q_sync (syn_in)
    );

    assign en_s   = syn_in[2];
    assign sclk_s = syn_in[1];
    assign dat_s  = syn_in[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            en_d   <= en_s;
            sclk_d <= sclk_s;
        end
    end

    logic en_fall, en_rise, sclk_rise;
    assign en_fall   = !en_s && en_d;
    assign en_rise   = en_s && !en_d;
    assign sclk_rise = sclk_s && !sclk_d;

    // ---- control FSM
    synp_state_t state, state_nx;

    logic                  shift_en;
    logic [FRAME_BITS-1:0] word;
    logic [CNT_W-1:0]      nbits;
    logic                  frame_ok;

    assign shift_en = sclk_rise && !en_s && (state == ST_FRAME);
    assign frame_ok = (nbits == CNT_W'(FRAME_BITS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (en_fall) state_nx = ST_FRAME;
            end
            ST_FRAME: begin
                if (en_rise) state_nx = frame_ok ? ST_COMMIT : ST_DROP;
            end
            ST_COMMIT: begin
                state_nx = en_fall ? ST_FRAME : ST_IDLE;
            end
            ST_DROP: begin
                state_nx = en_fall ? ST_FRAME : ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // ---- outputs of the FSM
    always_comb begin
        div_load = 1'b0;
        unique case (state)
            ST_COMMIT: div_load = 1'b1;
            ST_IDLE, ST_FRAME, ST_DROP: div_load = 1'b0;
            default: div_load = 1'b0;
        endcase
    end

    // ---- shift register and frame length
    synp_shift #(
        .FRAME_BITS(FRAME_BITS)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (en_fall),
        .shift_en(shift_en),
        .bit_in  (dat_s),
        .word    (word),
        .nbits   (nbits)
    );

    // ---- held counts, taken on entry to ST_COMMIT
    logic [A_W-1:0] a_q;
    logic [M_W-1:0] m_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            m_q <= '0;
        end else if (state == ST_FRAME && en_rise && frame_ok) begin
            a_q <= word[A_W-1:0];
            m_q <= word[FRAME_BITS-1:A_W];
        end
    end

    assign a_count = a_q;
    assign m_count = M_CW'(M_BASE) + M_CW'(m_q);

    // ---- charge pump blanking
    synp_blank #(
        .BLANK_CYCLES(BLANK_CYCLES)
    ) u_blank (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (en_fall),
        .blank_o(cp_blank)
    );

    // R5: the strobe lasts one cycle
    a_r5_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |=> !div_load);

    // R5: a strobe only follows a full-length frame closing
    a_r5_load_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |-> ($past(nbits) == CNT_W'(FRAME_BITS) && $past(en_rise)));

    // R6: counts move only in a strobe cycle
    a_r6_counts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !div_load |-> ($stable(a_count) && $stable(m_count)));

    // R4: modulus stays inside its four legal values
    a_r4_m_range: assert property (@(posedge clk) disable iff (!rst_n)
        (m_count >= M_CW'(M_BASE)) && (m_count <= M_CW'(M_BASE + (1 << M_W) - 1)));

    // R7: blanking only opens after a synchronised enable fall
    a_r7_blank_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cp_blank) |-> $past(en_fall));

    // R8: no shifting while the enable is high
    a_r8_no_idle_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && en_d) |=> $stable(nbits));

endmodule

// File: tb/synp_loader_bench.sv
module synp_loader_bench;

    localparam int BLANK = 16;

    logic       clk;
    logic       rst_n;
    logic       ser_en_n;
    logic       ser_clk;
    logic       ser_dat;
    logic [5:0] a_count;
    logic [5:0] m_count;
    logic       div_load;
    logic       cp_blank;

    synp_loader u_synp_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_en_n(ser_en_n),
        .ser_clk (ser_clk),
        .ser_dat (ser_dat),
        .a_count (a_count),
        .m_count (m_count),
        .div_load(div_load),
        .cp_blank(cp_blank)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // scoreboard queues
    logic [5:0] q_a[$];
    logic [5:0] q_m[$];
    int         q_c[$];

    logic [5:0] hold_a = 6'd0;
    logic [5:0] hold_m = 6'd49;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: strobe comparison
    logic prev_load = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (div_load) begin
                if (q_a.size() == 0) begin
                    check("R6 unexpected strobe", 1, 0);
                end else begin
                    logic [5:0] ea, em;
                    int ec;
                    ea = q_a.pop_front();
                    em = q_m.pop_front();
                    ec = q_c.pop_front();
                    check("R3 a_count", int'(a_count), int'(ea));
                    check("R4 m_count", int'(m_count), int'(em));
                    check("R5 strobe cycle", cyc, ec);
                end
                if (prev_load) check("R5 strobe width", 2, 1);
            end
            prev_load = div_load;
        end
    end

    // monitor: blanking run length
    int blank_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cp_blank) begin
                blank_run++;
            end else if (blank_run > 0) begin
                check("R7 blank length", blank_run, BLANK);
                blank_run = 0;
            end
        end
    end

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_frame(input int nb, input logic [7:0] w, input bit good);
        @(negedge clk);
        ser_en_n = 1'b0;
        wait_neg(2);
        check("R7 blank not yet", int'(cp_blank), 0);
        wait_neg(1);
        check("R7 blank rise", int'(cp_blank), 1);
        wait_neg(2);
        for (int i = 0; i < nb; i++) begin
            ser_dat = (i < 8) ? w[7-i] : 1'b1;  // R2 d7 first
            wait_neg(2);
            ser_clk = 1'b1;
            wait_neg(4);
            ser_clk = 1'b0;
            wait_neg(2);
        end
        wait_neg(BLANK);
        if (good) begin
            q_a.push_back(w[5:0]);
            q_m.push_back(6'd49 + 6'(w[7:6]));
            q_c.push_back(cyc + 3);
        end
        ser_en_n = 1'b1;
        wait_neg(8);
        if (good) begin
            hold_a = w[5:0];
            hold_m = 6'd49 + 6'(w[7:6]);
        end else begin
            check("R6 a held", int'(a_count), int'(hold_a));
            check("R6 m held", int'(m_count), int'(hold_m));
        end
        check("R5 queue drained", q_a.size(), 0);
    endtask

    initial begin
        rst_n    = 1'b0;
        ser_en_n = 1'b1;
        ser_clk  = 1'b0;
        ser_dat  = 1'b0;
        wait_neg(4);
        check("R1 a reset", int'(a_count), 0);
        check("R1 m reset", int'(m_count), 49);
        check("R1 load reset", int'(div_load), 0);
        check("R1 blank reset", int'(cp_blank), 0);
        rst_n = 1'b1;
        wait_neg(4);
        check("R1 idle blank", int'(cp_blank), 0);

        send_frame(8, 8'h05, 1'b1);  // R3 A=5, R4 code 00 -> 49
        send_frame(8, 8'h70, 1'b1);  // A=48, d6=1 -> 50
        send_frame(8, 8'h81, 1'b1);  // A=1, d7=1 -> 51
        send_frame(8, 8'hC4, 1'b1);  // A=4 -> 52
        send_frame(7, 8'h3F, 1'b0);  // R6 short frame
        send_frame(9, 8'h3F, 1'b0);  // R6 long frame
        send_frame(0, 8'h00, 1'b0);  // R6 empty frame
        send_frame(8, 8'hFF, 1'b1);  // A=63, M=52
        send_frame(8, 8'h2A, 1'b1);  // R2 alternating bits

        // R8: serial clock toggles with enable high
        for (int i = 0; i < 10; i++) begin
            ser_dat = i[0];
            wait_neg(2);
            ser_clk = 1'b1;
            wait_neg(3);
            ser_clk = 1'b0;
            wait_neg(3);
        end
        check("R8 a unchanged", int'(a_count), int'(hold_a));
        check("R8 m unchanged", int'(m_count), int'(hold_m));
        check("R8 no blank", int'(cp_blank), 0);

        send_frame(8, 8'h40, 1'b1);  // A=0, M=50 after idle clocking
        wait_neg(30);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_neg(100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule